// File: doc/BRIEF.md
# Multi-Channel PWM DAC Bank

The block produces thirteen 8-bit pulse-width-modulated outputs from one shared 8-bit step counter. A step-enable input is pulsed once per step (62.5 ns in the intended system). Each 256-step frame gives one PWM period. A channel programmed with value m leaves its pin released for the first m steps of the frame. It pulls the pin to ground for the remaining 256 − m steps. The outputs are open-drain: the block drives a per-channel pull-low enable and never drives a high level.

Software reaches the block through a plain register port: an address, write data, a write strobe and a combinational read-data bus. Each channel has a duty register that can be written and read back. A written value is staged and becomes the active value only when the counter wraps. A frame is therefore never cut short or stretched by a write.

Channels 0 to 6 are always PWM. Channels 7 to 12 each share a pin with a general-purpose port and are handed to PWM by an active-low select register. External claim inputs force some channels off their pins. Two ADC claim lines act on channels 0 and 1, and one serial-bus claim line acts on channels 4 and 5. The block reports which pins it owns. This is a control block with no data stream, so the register port has no valid/ready handshake: a write takes effect on the clock edge where the strobe is high, and the port never applies back-pressure.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset, every duty register reads 80h, the shared-select register reads 3Fh, `pwm_own` equals 007Fh, and all owned pins are released while the counter is at 0.
- R2: The duty register of channel i sits at address 30h+i for i = 0..6 and at 31h+i for i = 7..12. A read returns the value most recently written.
- R3: Address 37h is unused: a read there returns 00h, and a write there changes no duty register.
- R4: The shared counter and every output change only on clock edges where `step_en` is 1. With `step_en` held at 0, `pull_low` stays constant.
- R5: With active duty m, an owned channel is released for exactly m steps and pulled low for 256 − m steps of each frame. At count c the pin is released when c < m, so 00h gives a pin that is low for the whole frame.
- R6: A duty write becomes active only at the next counter wrap (255 → 0). The rest of the current frame keeps the old value.
- R7: The shared-select register is at address 2Fh. Bit k (k = 0..5) belongs to channel 7+k, and a 0 in that bit gives the pin to PWM. Bits 7:6 read as 0.
- R8: A channel whose pin is not owned keeps `pull_low` at 0.
- R9: `adc_claim[0]` and `adc_claim[1]` take the pins of channels 0 and 1, and `i2c_claim` takes the pins of channels 4 and 5. A claimed channel shows 0 in `pwm_own`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Advances the shared counter by one step |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| adc_claim | input | 2 | ADC takes the pins of channels 0 and 1 |
| i2c_claim | input | 1 | Serial bus takes the pins of channels 4 and 5 |
| pwm_own | output | 13 | 1 where PWM owns the pin |
| pull_low | output | 13 | 1 where the pin is driven to ground |

## Verification
The bench builds the block with its default parameters: 8-bit duty, seven fixed and six shared channels, and a base address of 30h. With these values the hole sits at 37h and the select register at 2Fh, exactly as the requirements give them. `step_en` is held high for most of the run, so one frame lasts 256 clock cycles. This puts the extreme duty values 00h, 01h and FFh within reach, along with a write made in mid-frame and its deferral to the wrap. Holding `step_en` low for a stretch shows that the counter and the outputs freeze.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  // Reset duty value: half scale
  localparam logic [7:0] DUTY_RESET = 8'h80;
  // Channels whose pins can be taken by external functions
  localparam int ADC_CH_A = 0;
  localparam int ADC_CH_B = 1;
  localparam int SER_CH_A = 4;
  localparam int SER_CH_B = 5;

  // Address offset of a channel: fixed channels are packed, the shared
  // ones sit one slot higher, leaving a hole after the fixed group.
  function automatic int chan_ofs(input int idx, input int nfixed);
    return (idx < nfixed) ? idx : idx + 1;
  endfunction
endpackage

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap    = step_en && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_nxt;
  end

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_dac_pkg::*;
#(
  parameter int W         = 8,
  parameter int AW        = 8,
  parameter int NUM_FIXED = 7,
  parameter int NUM_SHR   = 6,
  parameter int DUTY_BASE = 'h30,
  parameter int SEL_ADDR  = 'h2F,
  localparam int NUM_CH   = NUM_FIXED + NUM_SHR
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [W-1:0]             wdata,
  input  logic                     load,
  output logic [NUM_CH-1:0][W-1:0] active,
  output logic [NUM_CH-1:0][W-1:0] staged,
  output logic [NUM_SHR-1:0]       sel_n,
  output logic [W-1:0]             rdata
);
  localparam logic [AW-1:0] HOLE_A = AW'(DUTY_BASE + NUM_FIXED);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_duty
    localparam logic [AW-1:0] MY_A = AW'(DUTY_BASE + chan_ofs(i, NUM_FIXED));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged[i] <= W'(DUTY_RESET);
        active[i] <= W'(DUTY_RESET);
      end else begin
        if (wr && addr == MY_A) staged[i] <= wdata;
        if (load)               active[i] <= staged[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             sel_n <= '1;
    else if (wr && addr == AW'(SEL_ADDR))   sel_n <= wdata[NUM_SHR-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == AW'(DUTY_BASE + chan_ofs(i, NUM_FIXED))) rdata = staged[i];
    if (addr == AW'(SEL_ADDR)) rdata = {{(W-NUM_SHR){1'b0}}, sel_n};
  end

  AST_HOLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == HOLE_A) |=> $stable(staged)); // R3
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active)); // R6
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_dac_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         wrap,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] active,
  input  logic [W-1:0] staged,
  input  logic         own,
  output logic         pull_low
);
  logic [W-1:0] duty_nxt;
  logic         high_q;

  // At the wrap edge the staged value becomes the one in force
  assign duty_nxt = wrap ? staged : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       high_q <= (DUTY_RESET != 8'h00); // count 0 vs reset duty
    else if (step_en) high_q <= (cnt_nxt < duty_nxt);
  end

  assign pull_low = own & ~high_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(high_q)); // R4
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && duty_nxt == '0) |=> !high_q); // R5
  AST_FRAME_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && cnt_nxt == '0 && duty_nxt != '0) |=> high_q); // R5
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int W         = 8,
  parameter int AW        = 8,
  parameter int NUM_FIXED = 7,
  parameter int NUM_SHR   = 6,
  parameter int DUTY_BASE = 'h30,
  parameter int SEL_ADDR  = 'h2F,
  localparam int NUM_CH   = NUM_FIXED + NUM_SHR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [1:0]        adc_claim,
  input  logic              i2c_claim,
  output logic [NUM_CH-1:0] pwm_own,
  output logic [NUM_CH-1:0] pull_low
);
  logic [W-1:0]             cnt_nxt;
  logic                     wrap;
  logic [NUM_CH-1:0][W-1:0] active;
  logic [NUM_CH-1:0][W-1:0] staged;
  logic [NUM_SHR-1:0]       sel_n;
  logic [NUM_CH-1:0]        claimed;

  pwm_frame_ctr #(.W(W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step_en(step_en),
    .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  pwm_regfile #(
    .W(W), .AW(AW), .NUM_FIXED(NUM_FIXED), .NUM_SHR(NUM_SHR),
    .DUTY_BASE(DUTY_BASE), .SEL_ADDR(SEL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .load(wrap), .active(active), .staged(staged),
    .sel_n(sel_n), .rdata(reg_rdata)
  );

  always_comb begin
    claimed           = '0;
    claimed[ADC_CH_A] = adc_claim[0];
    claimed[ADC_CH_B] = adc_claim[1];
    claimed[SER_CH_A] = i2c_claim;
    claimed[SER_CH_B] = i2c_claim;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic picked;
    if (i < NUM_FIXED) begin : g_fixed
      assign picked = 1'b1;
    end else begin : g_shared
      assign picked = ~sel_n[i-NUM_FIXED];
    end
    assign pwm_own[i] = picked & ~claimed[i];

    pwm_chan #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .wrap(wrap),
      .cnt_nxt(cnt_nxt), .active(active[i]), .staged(staged[i]),
      .own(pwm_own[i]), .pull_low(pull_low[i])
    );
  end

  AST_ADC_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_claim[0] |-> !pwm_own[ADC_CH_A] && !pull_low[ADC_CH_A]); // R9
  AST_SER_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_claim |-> !pull_low[SER_CH_A] && !pull_low[SER_CH_B]); // R9
  AST_UNOWNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_low & ~pwm_own) == '0)); // R8
endmodule

// File: tb/tb_pwm_dac_bank.sv
module tb_pwm_dac_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        step_en = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [1:0]  adc_claim = 0;
  logic        i2c_claim = 0;
  logic [12:0] pwm_own;
  logic [12:0] pull_low;

  int total = 0;
  int bad   = 0;
  int ph    = 0;
  bit done  = 0;

  pwm_dac_bank dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adc_claim(adc_claim), .i2c_claim(i2c_claim),
    .pwm_own(pwm_own), .pull_low(pull_low)
  );

  always #10 clk = ~clk;

  // Expected step position from the requirements: +1 per enabled step
  always @(posedge clk) begin
    if (!rst_n)       ph <= 0;
    else if (step_en) ph <= (ph + 1) % 256;
  end

  function automatic logic [7:0] addr_of(input int ch);
    return (ch < 7) ? 8'(8'h30 + ch) : 8'(8'h31 + ch);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    if (ph == 255) @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_ph(input int p);
    @(negedge clk);
    while (ph != p) @(negedge clk);
  endtask

  // Released samples of one channel over a full frame
  task automatic measure(input int ch, output int rel);
    rel = 0;
    wait_ph(0);
    for (int k = 0; k < 256; k++) begin
      if (!pull_low[ch]) rel++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk);
    chk(pwm_own, 13'h007F, "R1 own");
    chk(pull_low, 0, "R1 pull_low at count 0");
    for (int c = 0; c < 13; c++) begin
      rd(addr_of(c), d);
      chk(d, 8'h80, "R1 duty reset");
    end
    rd(8'h2F, d);
    chk(d, 8'h3F, "R1 select reset");
  endtask

  task automatic t_hole;
    logic [7:0] d;
    wr(8'h37, 8'h55);
    rd(8'h37, d); chk(d, 0, "R3 hole read");
    for (int c = 0; c < 13; c++) begin
      rd(addr_of(c), d);
      chk(d, 8'h80, "R3 hole write ignored");
    end
  endtask

  task automatic t_map;
    logic [7:0] d;
    for (int c = 0; c < 13; c++) wr(addr_of(c), 8'(8'h10 + c));
    for (int c = 0; c < 13; c++) begin
      rd(addr_of(c), d);
      chk(d, 8'h10 + c, "R2 readback");
    end
    for (int c = 0; c < 13; c++) wr(addr_of(c), 8'h80);
  endtask

  task automatic t_duty;
    int rel;
    logic [7:0] vals [4] = '{8'h00, 8'h01, 8'h40, 8'hFF};
    for (int v = 0; v < 4; v++) begin
      wr(addr_of(3), vals[v]);
      measure(3, rel);
      chk(rel, vals[v], "R5 released steps");
    end
  endtask

  task automatic t_defer;
    int rel = 0;
    wr(addr_of(2), 8'h80);
    measure(2, rel);
    wait_ph(64);
    reg_addr = addr_of(2); reg_wdata = 8'h00; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    while (ph != 0) begin
      if (!pull_low[2]) rel++;
      @(negedge clk);
    end
    chk(rel - 128, 63, "R6 old duty kept in frame");
    measure(2, rel);
    chk(rel, 0, "R6 new duty next frame");
  endtask

  task automatic t_step_gate;
    logic [12:0] snap;
    int p0;
    wait_ph(100);
    step_en = 0;
    @(negedge clk);
    snap = pull_low; p0 = ph;
    repeat (40) @(negedge clk);
    chk(pull_low, snap, "R4 outputs frozen");
    chk(ph, p0, "R4 count frozen");
    step_en = 1;
  endtask

  task automatic t_select;
    int rel;
    logic [7:0] d;
    measure(10, rel);
    chk(rel, 256, "R8 unowned shared channel quiet");
    wr(8'h2F, 8'hFB);
    rd(8'h2F, d); chk(d, 8'h3B, "R7 select readback");
    @(negedge clk);
    chk(pwm_own, 13'h027F, "R7 channel 9 owned");
    wr(addr_of(9), 8'h40);
    measure(9, rel);
    chk(rel, 64, "R7 channel 9 runs PWM");
  endtask

  task automatic t_claims;
    int rel;
    wr(addr_of(0), 8'h00);
    adc_claim = 2'b01;
    @(negedge clk);
    chk(pwm_own[0], 0, "R9 adc claim ch0");
    measure(0, rel);
    chk(rel, 256, "R9 claimed ch0 quiet");
    adc_claim = 2'b10; i2c_claim = 1;
    @(negedge clk);
    chk(pwm_own & 13'h0033, 13'h0001, "R9 claims ch1 ch4 ch5");
    adc_claim = 0; i2c_claim = 0;
    measure(0, rel);
    chk(rel, 0, "R9 ch0 back after release");
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    step_en = 1;
    t_hole;
    t_map;
    t_duty;
    t_defer;
    t_step_gate;
    t_select;
    t_claims;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule